// File: doc/BRIEF.md
# Ring-Buffer Chunk Copy Engine

This block is a host-side hardware engine that moves a boot image from a shared SRAM ring into a destination memory, one chunk at a time. A doorbell handshake with a peer engine runs over two 32-bit registers. The engine drives a host-to-peer register and samples a peer-to-host status word. The host starts by posting a request word that carries the image size. It then waits for the peer to report how many ring slots it uses and how many bytes will follow.

Slot readiness uses parity. A slot is ready when the peer's low status bit for it differs from the host's matching bit. The host hands the slot back by inverting its own bit, so it never sets or clears a bit explicitly. Slots are serviced strictly in order: chunk index modulo slot count. Each chunk is moved one 32-bit word per beat over a read port and a write port, both valid/ready. After the last chunk the engine waits for the peer's completion flag and reports the outcome on single-cycle pulses.

A poll timer guards every wait on the peer. A per-copy length limit stops the engine before it oversteps what the ring can hold.

Top module: `ring_chunk_copier`

## Requirements
- R1: One cycle after `start_i` is sampled in idle, `h2p_wr_o` pulses and `h2p_o` equals `{img_size_i,4'h0}` ORed with 0xC0000000.
- R2: The engine polls status bits [29:28] until they are non-zero. Code 1 selects 1 slot, code 2 selects 2 slots and code 3 selects 4 slots. The byte count is (status AND 0x0FFFC000) shifted right by 4.
- R3: The slot serviced next is the chunk index modulo the slot count. No read is issued until that slot's bit differs between status[3:0] and `h2p_o[3:0]`; readiness of any other slot has no effect.
- R4: Word n of a chunk with slot s and index k is read from SRAM_BASE + chunk·s + 4n and written to dst_base + chunk·k + 4n. Full words carry byte enable 4'hF.
- R5: The chunk size is SRAM_BYTES divided by the slot count. Each copy moves min(chunk size, bytes remaining), and one acknowledge follows each copy.
- R6: Each acknowledge write inverts exactly bit (1 << slot) of `h2p_o` and pulses `h2p_wr_o`.
- R7: If a copy length exceeds COPY_LIMIT, `err_o` pulses, no memory access is made for that copy and the engine returns to idle.
- R8: Once no bytes remain, `done_o` pulses only after status bit 10 is set. `ok_o` pulses with it if status bit 9 is set; `ok_o` never pulses without `done_o`.
- R9: If a wait on the peer lasts POLL_LIMIT cycles, `err_o` pulses and the engine goes idle.
- R10: `busy_o` is high from the cycle after start until the cycle a result pulse appears, and is low with it. Each pulse lasts one cycle.
- R11: After reset the engine is idle: no pulses, no memory requests and `h2p_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled in idle |
| img_size_i | input | SIZE_W | Image size placed in the request word |
| dst_base_i | input | 32 | Destination base address |
| h2p_o | output | 32 | Host-to-peer register value |
| h2p_wr_o | output | 1 | Write strobe for `h2p_o` |
| p2h_i | input | 32 | Peer-to-host status word |
| rd_valid_o | output | 1 | SRAM read request |
| rd_addr_o | output | 32 | SRAM read byte address |
| rd_ready_i | input | 1 | Read accepted; `rd_data_i` valid |
| rd_data_i | input | 32 | Read data |
| wr_valid_o | output | 1 | Destination write request |
| wr_addr_o | output | 32 | Destination byte address |
| wr_data_o | output | 32 | Write data |
| wr_be_o | output | 4 | Write byte enables |
| wr_ready_i | input | 1 | Write accepted |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Completion pulse |
| ok_o | output | 1 | Peer-confirmed success pulse |
| err_o | output | 1 | Limit or timeout error pulse |

## Verification
A wrong slot index or a mismatched chunk size shows at the ports within the first word of the second chunk. It appears as a read address or write data off the expected SRAM pattern, or as an acknowledge that inverts the wrong `h2p_o` bit. A miscounted remaining length shows as an extra or missing acknowledge and a wrong word count when `done_o` arrives. A broken readiness test shows as reads issued while only a foreign slot is ready. A stuck wait shows as `err_o` after exactly the poll limit.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_CNT, ST_WAIT_SLOT, ST_RD, ST_WR, ST_ACK, ST_WAIT_FIN
  } rcc_state_e;

  localparam logic [31:0] REQ_TAG   = 32'hC000_0000;
  localparam logic [31:0] SIZE_MASK = 32'h0FFF_C000;
  localparam int unsigned CNT_LSB   = 28;
  localparam int unsigned FIN_BIT   = 10;
  localparam int unsigned OK_BIT    = 9;
endpackage

// File: rtl/rcc_status_decode.sv
module rcc_status_decode import rcc_pkg::*; (
  input  logic [31:0] status_i,
  input  logic [3:0]  host_low_i,
  input  logic [1:0]  slot_sel_i,
  output logic        cnt_vld_o,
  output logic [1:0]  slots_l2_o,
  output logic [31:0] bytes_o,
  output logic        slot_rdy_o,
  output logic        fin_o,
  output logic        fin_ok_o
);
  logic [1:0] cnt;
  logic [3:0] diff;

  assign cnt        = status_i[CNT_LSB +: 2];
  assign cnt_vld_o  = (cnt != 2'd0);
  // code 3 means four slots
  assign slots_l2_o = (cnt == 2'd3) ? 2'd2 : (cnt == 2'd2) ? 2'd1 : 2'd0;
  assign bytes_o    = (status_i & SIZE_MASK) >> 4;
  assign diff       = status_i[3:0] ^ host_low_i;
  assign slot_rdy_o = diff[slot_sel_i];
  assign fin_o      = status_i[FIN_BIT];
  assign fin_ok_o   = status_i[OK_BIT];
endmodule

// File: rtl/rcc_poll_timer.sv
module rcc_poll_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  assign expired_o = (cnt_q == CW'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (run_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ring_chunk_copier.sv
module ring_chunk_copier import rcc_pkg::*; #(
  parameter int unsigned SIZE_W     = 24,
  parameter logic [31:0] SRAM_BYTES = 32'h0002_0000,
  parameter logic [31:0] SRAM_BASE  = 32'hFFF0_0000,
  parameter logic [31:0] COPY_LIMIT = 32'h0000_9BE2,
  parameter int unsigned POLL_LIMIT = 100000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SIZE_W-1:0] img_size_i,
  input  logic [31:0]       dst_base_i,
  output logic [31:0]       h2p_o,
  output logic              h2p_wr_o,
  input  logic [31:0]       p2h_i,
  output logic              rd_valid_o,
  output logic [31:0]       rd_addr_o,
  input  logic              rd_ready_i,
  input  logic [31:0]       rd_data_i,
  output logic              wr_valid_o,
  output logic [31:0]       wr_addr_o,
  output logic [31:0]       wr_data_o,
  output logic [3:0]        wr_be_o,
  input  logic              wr_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ok_o,
  output logic              err_o
);
  localparam int unsigned PAD_W = 32 - SIZE_W - 4;

  rcc_state_e  state_q, state_prev_q;
  logic [31:0] h2p_q, left_q, len_q, off_q, dst_q, idx_q, data_q;
  logic [1:0]  sl2_q;
  logic        h2p_wr_q, done_q, ok_q, err_q;

  logic        cnt_vld, slot_rdy, fin, fin_ok, waiting, tmo_exp;
  logic [1:0]  sl2_dec, slot_sel;
  logic [31:0] bytes_dec, chunk_sz, copy_len, rem, req_word;

  assign req_word = REQ_TAG | {{PAD_W{1'b0}}, img_size_i, 4'h0};
  assign chunk_sz = SRAM_BYTES >> sl2_q;
  assign slot_sel = idx_q[1:0] & ~(2'b11 << sl2_q);
  assign copy_len = (left_q < chunk_sz) ? left_q : chunk_sz;
  assign waiting  = (state_q == ST_WAIT_CNT) || (state_q == ST_WAIT_SLOT) ||
                    (state_q == ST_WAIT_FIN);
  assign rem      = len_q - off_q;

  rcc_status_decode u_dec (
    .status_i   (p2h_i),
    .host_low_i (h2p_q[3:0]),
    .slot_sel_i (slot_sel),
    .cnt_vld_o  (cnt_vld),
    .slots_l2_o (sl2_dec),
    .bytes_o    (bytes_dec),
    .slot_rdy_o (slot_rdy),
    .fin_o      (fin),
    .fin_ok_o   (fin_ok)
  );

  // window restarts on every state change
  rcc_poll_timer #(.LIMIT(POLL_LIMIT)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!waiting || (state_q != state_prev_q)),
    .run_i     (waiting),
    .expired_o (tmo_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      state_prev_q <= ST_IDLE;
      h2p_q        <= '0;
      left_q       <= '0;
      len_q        <= '0;
      off_q        <= '0;
      dst_q        <= '0;
      idx_q        <= '0;
      data_q       <= '0;
      sl2_q        <= '0;
      h2p_wr_q     <= 1'b0;
      done_q       <= 1'b0;
      ok_q         <= 1'b0;
      err_q        <= 1'b0;
    end else begin
      state_prev_q <= state_q;
      h2p_wr_q     <= 1'b0;
      done_q       <= 1'b0;
      ok_q         <= 1'b0;
      err_q        <= 1'b0;
      if (waiting && tmo_exp) begin
        err_q   <= 1'b1;
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start_i) begin
            h2p_q    <= req_word;
            h2p_wr_q <= 1'b1;
            dst_q    <= dst_base_i;
            state_q  <= ST_WAIT_CNT;
          end
          ST_WAIT_CNT: if (cnt_vld) begin
            sl2_q   <= sl2_dec;
            left_q  <= bytes_dec;
            idx_q   <= '0;
            state_q <= (bytes_dec == '0) ? ST_WAIT_FIN : ST_WAIT_SLOT;
          end
          ST_WAIT_SLOT: if (slot_rdy) begin
            if (copy_len > COPY_LIMIT) begin
              err_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              len_q   <= copy_len;
              off_q   <= '0;
              state_q <= ST_RD;
            end
          end
          ST_RD: if (rd_ready_i) begin
            data_q  <= rd_data_i;
            state_q <= ST_WR;
          end
          ST_WR: if (wr_ready_i) begin
            off_q   <= off_q + 32'd4;
            dst_q   <= dst_q + 32'd4;
            state_q <= (off_q + 32'd4 >= len_q) ? ST_ACK : ST_RD;
          end
          ST_ACK: begin
            h2p_q    <= h2p_q ^ (32'h1 << slot_sel);
            h2p_wr_q <= 1'b1;
            left_q   <= left_q - len_q;
            idx_q    <= idx_q + 32'd1;
            state_q  <= (left_q == len_q) ? ST_WAIT_FIN : ST_WAIT_SLOT;
          end
          ST_WAIT_FIN: if (fin) begin
            done_q  <= 1'b1;
            ok_q    <= fin_ok;
            state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign h2p_o      = h2p_q;
  assign h2p_wr_o   = h2p_wr_q;
  assign rd_valid_o = (state_q == ST_RD);
  assign rd_addr_o  = SRAM_BASE + chunk_sz * {30'd0, slot_sel} + off_q;
  assign wr_valid_o = (state_q == ST_WR);
  assign wr_addr_o  = dst_q;
  assign wr_data_o  = data_q;
  assign wr_be_o    = (rem >= 32'd4) ? 4'hF : (4'hF >> (3'd4 - rem[2:0]));
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign ok_o       = ok_q;
  assign err_o      = err_q;
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic        ok_o,
  input logic        err_o,
  input logic [31:0] h2p_o,
  input logic        h2p_wr_o,
  input logic        rd_valid_o,
  input logic        wr_valid_o,
  input logic        wr_ready_i,
  input logic [31:0] wr_addr_o
);
  p_req_word_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h2p_wr_o && !$past(busy_o)) |-> (h2p_o[31:30] == 2'b11 && h2p_o[3:0] == 4'h0));

  p_wr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o)));

  p_ack_one_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h2p_wr_o && $past(busy_o)) |-> ($countones(h2p_o ^ $past(h2p_o)) == 1));

  p_ok_with_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> done_o);

  p_pulse_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> !busy_o);

  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_err_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!rd_valid_o && !wr_valid_o));
endmodule

bind ring_chunk_copier rcc_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .ok_o       (ok_o),
  .err_o      (err_o),
  .h2p_o      (h2p_o),
  .h2p_wr_o   (h2p_wr_o),
  .rd_valid_o (rd_valid_o),
  .wr_valid_o (wr_valid_o),
  .wr_ready_i (wr_ready_i),
  .wr_addr_o  (wr_addr_o)
);

// File: tb/tb_ring_chunk_copier.sv
`timescale 1ns/1ps
module tb_ring_chunk_copier;
  localparam logic [31:0] SRAM_B = 32'd8192;
  localparam logic [31:0] BASE   = 32'h4000_0000;
  localparam logic [31:0] LIM    = 32'd4096;
  localparam int          POLL   = 200;
  localparam logic [31:0] KEY    = 32'hA5A5_0000;

  typedef struct packed {
    logic [1:0]  code;
    logic [31:0] bytes;
    logic        fin_ok;
    logic        exp_err;
    logic [15:0] words;
    logic [7:0]  acks;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd1, 32'd1024,  1'b1, 1'b0, 16'd256,  8'd1},
    '{2'd3, 32'd3072,  1'b1, 1'b0, 16'd768,  8'd2},
    '{2'd3, 32'd10240, 1'b1, 1'b0, 16'd2560, 8'd5},
    '{2'd2, 32'd4096,  1'b0, 1'b0, 16'd1024, 8'd1},
    '{2'd1, 32'd8192,  1'b1, 1'b1, 16'd0,    8'd0},
    '{2'd2, 32'd0,     1'b1, 1'b0, 16'd0,    8'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [23:0] img = '0;
  logic [31:0] dst = '0, h2p, p2h, rd_addr, rd_data, wr_addr, wr_data;
  logic [31:0] p2h_hi = '0;
  logic [3:0]  man_low = '0, rdy_mask = 4'h1, wr_be;
  logic auto_rdy = 1'b1, h2p_wr, rd_valid, wr_valid, busy, done, ok, err;
  logic rd_rdy = 1'b0, wr_rdy = 1'b0;

  int checks = 0, errors = 0, cyc = 0;
  int nw = 0, nr = 0, nack = 0, mism = 0, tog_bad = 0, slots_tb = 1, chunk_tb = 8192;
  logic [31:0] dst_tb = '0, prev_h2p = '0;
  bit prev_vld = 0, finished = 0;

  always #4 clk = ~clk;

  assign p2h     = {p2h_hi[31:4], auto_rdy ? (h2p[3:0] ^ rdy_mask) : man_low};
  assign rd_data = rd_addr ^ KEY;

  ring_chunk_copier #(
    .SIZE_W(24), .SRAM_BYTES(SRAM_B), .SRAM_BASE(BASE),
    .COPY_LIMIT(LIM), .POLL_LIMIT(POLL)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .img_size_i(img),
    .dst_base_i(dst), .h2p_o(h2p), .h2p_wr_o(h2p_wr), .p2h_i(p2h),
    .rd_valid_o(rd_valid), .rd_addr_o(rd_addr), .rd_ready_i(rd_rdy),
    .rd_data_i(rd_data), .wr_valid_o(wr_valid), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .wr_be_o(wr_be), .wr_ready_i(wr_rdy),
    .busy_o(busy), .done_o(done), .ok_o(ok), .err_o(err)
  );

  // memory and peer monitor: decides ready for the next edge, records handshakes
  always @(negedge clk) begin
    logic [31:0] b, ea, ed, et;
    cyc++;
    rd_rdy = (cyc % 5) != 0;
    wr_rdy = (cyc % 3) != 0;
    if (rd_valid && rd_rdy) nr++;
    if (wr_valid && wr_rdy) begin
      b  = nw * 4;
      ea = dst_tb + b;
      ed = (BASE + chunk_tb * ((b / chunk_tb) % slots_tb) + (b % chunk_tb)) ^ KEY;
      if (wr_addr !== ea || wr_data !== ed || wr_be !== 4'hF) begin
        if (mism == 0)
          $display("  write %0d: addr=%h/%h data=%h/%h be=%h", nw, wr_addr, ea, wr_data, ed, wr_be);
        mism++;
      end
      nw++;
    end
    if (h2p_wr) begin
      if (prev_vld) begin
        et = 32'h1 << (nack % slots_tb);
        if ((h2p ^ prev_h2p) !== et) tog_bad++;
        nack++;
      end
      prev_h2p = h2p;
      prev_vld = 1;
    end
  end

  task automatic chk(input bit c, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic setup(input int slots);
    slots_tb = slots;
    chunk_tb = 8192 / slots;
    rdy_mask = (slots == 1) ? 4'h1 : (slots == 2) ? 4'h3 : 4'hF;
    nw = 0; nr = 0; nack = 0; mism = 0; tog_bad = 0; prev_vld = 0;
  endtask

  task automatic kick(input int i);
    @(negedge clk);
    img = 24'h000123 + 24'(i);
    dst_tb = 32'h8000_0000 + 32'(i) * 32'h10000;
    dst = dst_tb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_result(input int lim, output int n);
    n = 0;
    while (!(done || err) && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_vec(input vec_t v, input int i);
    int n;
    auto_rdy = 1'b1;
    p2h_hi = '0;
    setup((v.code == 2'd3) ? 4 : int'(v.code));
    kick(i);
    chk(h2p_wr == 1'b1 && h2p == (32'hC000_0000 | {4'h0, img, 4'h0}), "R1", "request word",
        h2p, 32'hC000_0000 | {4'h0, img, 4'h0});
    chk(busy, "R10", "busy after start", 32'(busy), 1);
    p2h_hi = {2'b00, v.code, 28'h0} | (v.bytes << 4) | 32'h400 | (v.fin_ok ? 32'h200 : 32'h0);
    wait_result(40000, n);
    chk(err == v.exp_err, "R7", "error pulse", 32'(err), 32'(v.exp_err));
    chk(done == !v.exp_err, "R8", "done pulse", 32'(done), 32'(!v.exp_err));
    chk(ok == (v.fin_ok && !v.exp_err), "R8", "ok flag", 32'(ok), 32'(v.fin_ok && !v.exp_err));
    chk(nw == int'(v.words), "R2", "words written", nw, 32'(v.words));
    chk(nr == int'(v.words), "R7", "words read", nr, 32'(v.words));
    chk(nack == int'(v.acks), "R5", "acknowledges", nack, 32'(v.acks));
    chk(mism == 0, "R4", "address/data mismatches", mism, 0);
    chk(tog_bad == 0, "R6", "ack toggle errors", tog_bad, 0);
    @(negedge clk);
    chk(!done && !err && !busy, "R10", "pulse width / idle", {29'd0, done, err, busy}, 0);
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !ok && !err, "R11", "idle outputs", {28'd0, busy, done, ok, err}, 0);
    chk(!rd_valid && !wr_valid && !h2p_wr, "R11", "no requests", {29'd0, rd_valid, wr_valid, h2p_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(h2p == 32'h0 && !busy, "R11", "register after reset", h2p, 0);

    for (int i = 0; i < 6; i++) run_vec(VECS[i], i);

    // R3: only a foreign slot ready, then the right one
    auto_rdy = 1'b0;
    man_low = 4'b0010;
    setup(4);
    p2h_hi = '0;
    kick(10);
    p2h_hi = {4'b0011, 28'h0} | (32'd2048 << 4) | 32'h600;
    repeat (40) @(negedge clk);
    chk(nr == 0 && busy, "R3", "reads with foreign slot ready", nr, 0);
    man_low = 4'b0011;
    wait_result(10000, n);
    chk(done && ok && nw == 512, "R3", "words after slot ready", nw, 512);

    // R8: completion only after flag
    auto_rdy = 1'b1;
    setup(1);
    p2h_hi = '0;
    kick(11);
    p2h_hi = {4'b0001, 28'h0};
    repeat (40) @(negedge clk);
    chk(!done && busy, "R8", "done before flag", 32'(done), 0);
    p2h_hi = p2h_hi | 32'h600;
    wait_result(10, n);
    chk(done && ok, "R8", "done after flag", {30'd0, done, ok}, 3);
    @(negedge clk);

    // R9: peer never answers
    auto_rdy = 1'b0;
    man_low = '0;
    p2h_hi = '0;
    setup(1);
    kick(12);
    wait_result(1000, n);
    chk(err && !done, "R9", "timeout error", {30'd0, err, done}, 2);
    chk(n >= POLL - 2 && n <= POLL + 6, "R9", "timeout latency", n, POLL);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule